// File: doc/BRIEF.md
# Dual-Port Mailbox with Doorbell Interrupts

This block holds sixteen byte-wide mailboxes that two bus masters share: a host-side port and a processor-side port. Each port reaches the mailboxes through a 32-bit word interface with four byte enables. Lane k of word w maps to mailbox 4w+k, so one full-word access touches four mailboxes at once.

Every access a port makes to a mailbox byte can ring a doorbell. Four enable sets select which doorbells count: host-side reads, host-side writes, processor-side reads and processor-side writes, each with one enable bit per mailbox. An enabled read sets that mailbox's bit in a 16-bit read-status field. An enabled write sets its bit in a 16-bit write-status field. The OR of all status bits drives an interrupt request toward each side. Software clears a status bit by writing 1 to it from either port.

Both ports share one register map, indexed by a 3-bit word address. Words 0 to 3 are the mailboxes. Word 4 holds the host-side enables: bits [15:0] for reads and bits [31:16] for writes. Word 5 holds the processor-side enables in the same layout. Word 6 holds the status: bits [15:0] for reads and bits [31:16] for writes. Word 7 reads as zero and ignores writes. Read data depends only on the address, is combinational from the current state, and does not need the request strobe.

Top module: `mbox_doorbell`

## Requirements
- R1: While rst_n is low at a clock edge, all mailboxes, enables and status bits return to zero, and both interrupt outputs are low after that edge.
- R2: A write to word w (w in 0..3) with byte enable k set stores wdata[8k+7:8k] in mailbox 4w+k. Lanes whose enable is clear keep their value. The new value can be read from either port after the edge.
- R3: A host-side access to a mailbox byte sets that mailbox's status bit at the next edge, if its host enable is set. A read uses word 4 bit i and sets status bit i. A write uses word 4 bit 16+i and sets status bit 16+i.
- R4: A processor-side access does the same using the enables in word 5.
- R5: An access to a mailbox byte whose matching enable bit is 0 leaves the status unchanged.
- R6: In a multi-byte access, each touched mailbox whose enable is set raises its own status bit.
- R7: pci_irq and dsp_irq both equal the OR of all 32 status bits. They change one edge after the event or clear that causes the change, and they hold steady while neither port makes a request.
- R8: Writing 1 to a status bit in word 6, from either port, clears it at the next edge. Bits written with 0, or in lanes whose byte enable is clear, are unchanged. If a clear and a new event hit the same bit in the same cycle, the bit ends cleared.
- R9: If both ports write the same mailbox byte, or the same enable byte, in the same cycle, the host-side value is stored. Each port's write event is still latched if that port's enable is set.
- R10: Accesses to words 4 to 7 raise no doorbell. Writes to word 7 change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| pci_req | input | 1 | Host-side access strobe |
| pci_we | input | 1 | Host-side write (1) or read (0) |
| pci_addr | input | 3 | Host-side word index |
| pci_be | input | 4 | Host-side byte enables |
| pci_wdata | input | 32 | Host-side write data |
| pci_rdata | output | 32 | Host-side read data for pci_addr |
| pci_irq | output | 1 | Interrupt request toward the host side |
| dsp_req | input | 1 | Processor-side access strobe |
| dsp_we | input | 1 | Processor-side write (1) or read (0) |
| dsp_addr | input | 3 | Processor-side word index |
| dsp_be | input | 4 | Processor-side byte enables |
| dsp_wdata | input | 32 | Processor-side write data |
| dsp_rdata | output | 32 | Processor-side read data for dsp_addr |
| dsp_irq | output | 1 | Interrupt request toward the processor side |

## Verification
Every stored result (mailbox bytes, enables, status and the two interrupts) updates at the first rising edge after the access that causes it. Read data shows that state without further delay. The bench drives each stimulus vector at a falling edge and lets one rising edge pass. At the next falling edge it drops both request strobes, points the host port at the status word and the processor port at the word under test, and samples 1 ns later. Because the strobes are low during sampling, the sampling reads cannot ring a doorbell themselves.

// File: rtl/mbox_doorbell.sv
module mbox_doorbell #(
  parameter int NMB = 16
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        pci_req,
  input  logic        pci_we,
  input  logic [2:0]  pci_addr,
  input  logic [3:0]  pci_be,
  input  logic [31:0] pci_wdata,
  output logic [31:0] pci_rdata,
  output logic        pci_irq,
  input  logic        dsp_req,
  input  logic        dsp_we,
  input  logic [2:0]  dsp_addr,
  input  logic [3:0]  dsp_be,
  input  logic [31:0] dsp_wdata,
  output logic [31:0] dsp_rdata,
  output logic        dsp_irq
);
  localparam int NW = NMB / 4;

  logic [7:0]       mb [NMB];
  logic [8*NMB-1:0] mb_flat;
  logic [31:0]      en_pci, en_dsp;
  logic [15:0]      st_rd, st_wr;

  logic [15:0] p_touch, d_touch;
  logic [15:0] p_rd_t, p_wr_t, d_rd_t, d_wr_t;
  logic [15:0] rd_evt, wr_evt;
  logic [31:0] p_bm, d_bm, clr;
  logic [31:0] pa_m, da_m, pb_m, db_m;
  logic        p_in_mb, d_in_mb;

  assign p_in_mb = pci_req && !pci_addr[2];
  assign d_in_mb = dsp_req && !dsp_addr[2];
  assign p_touch = {12'b0, pci_be & {4{p_in_mb}}} << {pci_addr[1:0], 2'b00};
  assign d_touch = {12'b0, dsp_be & {4{d_in_mb}}} << {dsp_addr[1:0], 2'b00};
  assign p_rd_t  = p_touch & {16{!pci_we}};
  assign p_wr_t  = p_touch & {16{pci_we}};
  assign d_rd_t  = d_touch & {16{!dsp_we}};
  assign d_wr_t  = d_touch & {16{dsp_we}};

  assign rd_evt = (p_rd_t & en_pci[15:0])  | (d_rd_t & en_dsp[15:0]);
  assign wr_evt = (p_wr_t & en_pci[31:16]) | (d_wr_t & en_dsp[31:16]);

  assign p_bm = {{8{pci_be[3]}}, {8{pci_be[2]}}, {8{pci_be[1]}}, {8{pci_be[0]}}};
  assign d_bm = {{8{dsp_be[3]}}, {8{dsp_be[2]}}, {8{dsp_be[1]}}, {8{dsp_be[0]}}};

  assign pa_m = p_bm & {32{pci_req && pci_we && pci_addr == 3'd4}};
  assign da_m = d_bm & {32{dsp_req && dsp_we && dsp_addr == 3'd4}} & ~pa_m;
  assign pb_m = p_bm & {32{pci_req && pci_we && pci_addr == 3'd5}};
  assign db_m = d_bm & {32{dsp_req && dsp_we && dsp_addr == 3'd5}} & ~pb_m;

  assign clr = (p_bm & pci_wdata & {32{pci_req && pci_we && pci_addr == 3'd6}})
             | (d_bm & dsp_wdata & {32{dsp_req && dsp_we && dsp_addr == 3'd6}});

  for (genvar i = 0; i < NMB; i++) begin : g_mb
    always_ff @(posedge clk) begin
      if (!rst_n)         mb[i] <= 8'h00;
      else if (p_wr_t[i]) mb[i] <= pci_wdata[8*(i%4) +: 8];
      else if (d_wr_t[i]) mb[i] <= dsp_wdata[8*(i%4) +: 8];
    end
    assign mb_flat[8*i +: 8] = mb[i];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      en_pci <= '0;
      en_dsp <= '0;
      st_rd  <= '0;
      st_wr  <= '0;
    end else begin
      en_pci <= (en_pci & ~(pa_m | da_m)) | (pci_wdata & pa_m) | (dsp_wdata & da_m);
      en_dsp <= (en_dsp & ~(pb_m | db_m)) | (pci_wdata & pb_m) | (dsp_wdata & db_m);
      st_rd  <= (st_rd | rd_evt) & ~clr[15:0];
      st_wr  <= (st_wr | wr_evt) & ~clr[31:16];
    end
  end

  function automatic logic [31:0] rd_word(input logic [2:0] a);
    case (a)
      3'd4:    rd_word = en_pci;
      3'd5:    rd_word = en_dsp;
      3'd6:    rd_word = {st_wr, st_rd};
      3'd7:    rd_word = '0;
      default: rd_word = mb_flat[32*a[1:0] +: 32];
    endcase
  endfunction

  assign pci_rdata = rd_word(pci_addr);
  assign dsp_rdata = rd_word(dsp_addr);
  assign pci_irq   = |{st_wr, st_rd};
  assign dsp_irq   = |{st_wr, st_rd};

  if (NW != 4) begin : g_bad_size
    initial $error("mbox_doorbell expects 16 mailboxes");
  end
endmodule

// File: rtl/mbox_doorbell_chk.sv
module mbox_doorbell_chk (
  input logic         clk,
  input logic         rst_n,
  input logic         pci_req,
  input logic         pci_we,
  input logic [2:0]   pci_addr,
  input logic [3:0]   pci_be,
  input logic [31:0]  pci_wdata,
  input logic         pci_irq,
  input logic         dsp_req,
  input logic         dsp_we,
  input logic [2:0]   dsp_addr,
  input logic [3:0]   dsp_be,
  input logic [31:0]  dsp_wdata,
  input logic         dsp_irq,
  input logic [31:0]  en_pci,
  input logic [31:0]  en_dsp,
  input logic [127:0] mb_flat
);
  logic p_stw, d_stw, p_mbw0;
  assign p_stw  = pci_req && pci_we && pci_addr == 3'd6;
  assign d_stw  = dsp_req && dsp_we && dsp_addr == 3'd6;
  assign p_mbw0 = pci_req && pci_we && !pci_addr[2] && pci_be[0];

  assert_reset_quiet_R1: assert property (@(posedge clk)
    !rst_n |=> (!pci_irq && !dsp_irq));

  assert_dsp_lane0_write_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (dsp_req && dsp_we && !dsp_addr[2] && dsp_be[0] && !(p_mbw0 && pci_addr == dsp_addr))
    |=> mb_flat[32*$past(dsp_addr[1:0]) +: 8] == $past(dsp_wdata[7:0]));

  assert_host_read_bell_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (pci_req && !pci_we && pci_addr == 3'd0 && pci_be[0] && en_pci[0] && !d_stw)
    |=> (pci_irq && dsp_irq));

  assert_dsp_write_bell_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (dsp_req && dsp_we && dsp_addr == 3'd3 && dsp_be[3] && en_dsp[31] && !p_stw)
    |=> (pci_irq && dsp_irq));

  assert_idle_steady_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (!pci_req && !dsp_req) |=> ($stable(pci_irq) && $stable(dsp_irq)));

  assert_full_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (p_stw && pci_be == 4'hF && pci_wdata == 32'hFFFF_FFFF && !dsp_req)
    |=> (!pci_irq && !dsp_irq));

  assert_host_wins_R9: assert property (@(posedge clk) disable iff (!rst_n)
    p_mbw0 |=> mb_flat[32*$past(pci_addr[1:0]) +: 8] == $past(pci_wdata[7:0]));
endmodule

bind mbox_doorbell mbox_doorbell_chk u_chk (.*);

// File: tb/mbox_doorbell_bench.sv
module mbox_doorbell_bench;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        pci_req, pci_we, dsp_req, dsp_we;
  logic [2:0]  pci_addr, dsp_addr;
  logic [3:0]  pci_be, dsp_be;
  logic [31:0] pci_wdata, dsp_wdata, pci_rdata, dsp_rdata;
  logic        pci_irq, dsp_irq;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  mbox_doorbell u_mbox_doorbell (
    .clk(clk), .rst_n(rst_n),
    .pci_req(pci_req), .pci_we(pci_we), .pci_addr(pci_addr), .pci_be(pci_be),
    .pci_wdata(pci_wdata), .pci_rdata(pci_rdata), .pci_irq(pci_irq),
    .dsp_req(dsp_req), .dsp_we(dsp_we), .dsp_addr(dsp_addr), .dsp_be(dsp_be),
    .dsp_wdata(dsp_wdata), .dsp_rdata(dsp_rdata), .dsp_irq(dsp_irq)
  );

  typedef struct packed {
    logic        pr; logic pw; logic [2:0] pa; logic [3:0] pb; logic [31:0] pd;
    logic        dr; logic dw; logic [2:0] da; logic [3:0] db; logic [31:0] dd;
    logic [2:0]  chk; logic [31:0] exp_d; logic [31:0] exp_st;
  } vec_t;

  localparam int NV = 17;
  localparam vec_t VEC [NV] = '{
    // R2 R5: full host write, no enables yet
    '{1,1,3'd0,4'hF,32'h44332211, 0,0,3'd0,4'h0,32'h0, 3'd0,32'h44332211,32'h0},
    // R2: processor write, lanes 0 and 2
    '{0,0,3'd0,4'h0,32'h0, 1,1,3'd1,4'h5,32'hAABBCCDD, 3'd1,32'h00BB00DD,32'h0},
    // R10: host enables all on, no bell
    '{1,1,3'd4,4'hF,32'hFFFFFFFF, 0,0,3'd0,4'h0,32'h0, 3'd4,32'hFFFFFFFF,32'h0},
    // R3 R6: host read lanes 0,1
    '{1,0,3'd0,4'h3,32'h0, 0,0,3'd0,4'h0,32'h0, 3'd0,32'h44332211,32'h3},
    // R5: processor read with its enables off
    '{0,0,3'd0,4'h0,32'h0, 1,0,3'd0,4'hF,32'h0, 3'd5,32'h0,32'h3},
    // R8: processor clears bit 0
    '{0,0,3'd0,4'h0,32'h0, 1,1,3'd6,4'hF,32'h1, 3'd6,32'h2,32'h2},
    // R8 R7: host clears bit 1, irq drops
    '{1,1,3'd6,4'h1,32'h2, 0,0,3'd0,4'h0,32'h0, 3'd6,32'h0,32'h0},
    // R3: host write mailbox 11
    '{1,1,3'd2,4'h8,32'h5A000000, 0,0,3'd0,4'h0,32'h0, 3'd2,32'h5A000000,32'h08000000},
    // R8 R10: host clear while processor sets its read enables 12..15
    '{1,1,3'd6,4'hF,32'h08000000, 1,1,3'd5,4'hF,32'h0000F000, 3'd5,32'h0000F000,32'h0},
    // R4 R6: processor read word 3
    '{0,0,3'd0,4'h0,32'h0, 1,0,3'd3,4'hF,32'h0, 3'd3,32'h0,32'h0000F000},
    // R8: clear beats same-cycle event on bit 12
    '{1,0,3'd3,4'h1,32'h0, 1,1,3'd6,4'hF,32'h00001000, 3'd6,32'h0000E000,32'h0000E000},
    // R9: both write mailbox 5, host wins, host write bell bit 21
    '{1,1,3'd1,4'h2,32'h00001100, 1,1,3'd1,4'h2,32'h00002200, 3'd1,32'h00BB11DD,32'h0020E000},
    // R8: host clears everything
    '{1,1,3'd6,4'hF,32'hFFFFFFFF, 0,0,3'd0,4'h0,32'h0, 3'd6,32'h0,32'h0},
    // R10: word 7 ignored
    '{1,1,3'd7,4'hF,32'hFFFFFFFF, 1,0,3'd7,4'hF,32'h0, 3'd7,32'h0,32'h0},
    // R4: processor write enables all on, read enables off
    '{0,0,3'd0,4'h0,32'h0, 1,1,3'd5,4'hF,32'hFFFF0000, 3'd5,32'hFFFF0000,32'h0},
    // R4 R6: processor write mailboxes 14,15
    '{0,0,3'd0,4'h0,32'h0, 1,1,3'd3,4'hC,32'h77660000, 3'd3,32'h77660000,32'hC0000000},
    // R8: byte 3 not enabled, status kept
    '{1,1,3'd6,4'h7,32'hFFFFFFFF, 0,0,3'd0,4'h0,32'h0, 3'd6,32'hC0000000,32'hC0000000}
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic idle(input logic [2:0] pa, input logic [2:0] da);
    pci_req = 0; pci_we = 0; pci_addr = pa; pci_be = 0; pci_wdata = 0;
    dsp_req = 0; dsp_we = 0; dsp_addr = da; dsp_be = 0; dsp_wdata = 0;
  endtask

  initial begin
    idle(3'd6, 3'd0);
    rst_n = 0;
    repeat (2) @(negedge clk);
    #1;
    check("R1 status", pci_rdata, 32'h0);
    check("R1 mailbox", dsp_rdata, 32'h0);
    check("R1 irq", {31'b0, pci_irq | dsp_irq}, 32'h0);
    rst_n = 1;
    @(negedge clk);

    for (int i = 0; i < NV; i++) begin
      pci_req = VEC[i].pr; pci_we = VEC[i].pw; pci_addr = VEC[i].pa;
      pci_be = VEC[i].pb; pci_wdata = VEC[i].pd;
      dsp_req = VEC[i].dr; dsp_we = VEC[i].dw; dsp_addr = VEC[i].da;
      dsp_be = VEC[i].db; dsp_wdata = VEC[i].dd;
      @(negedge clk);
      idle(3'd6, VEC[i].chk);
      #1;
      check($sformatf("R2/R10 data v%0d", i), dsp_rdata, VEC[i].exp_d);
      check($sformatf("R3/R4/R8 status v%0d", i), pci_rdata, VEC[i].exp_st);
      check($sformatf("R7 pci_irq v%0d", i), {31'b0, pci_irq}, {31'b0, VEC[i].exp_st != 0});
      check($sformatf("R7 dsp_irq v%0d", i), {31'b0, dsp_irq}, {31'b0, VEC[i].exp_st != 0});
    end

    // R7: idle cycle keeps irq
    @(negedge clk); #1;
    check("R7 idle hold", {31'b0, pci_irq}, 32'h1);

    // R1: reset mid-run
    rst_n = 0;
    @(negedge clk);
    rst_n = 1;
    idle(3'd3, 3'd5);
    #1;
    check("R1 mailbox after reset", pci_rdata, 32'h0);
    check("R1 enables after reset", dsp_rdata, 32'h0);
    check("R1 irq after reset", {31'b0, pci_irq | dsp_irq}, 32'h0);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule